// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles that a host issues to a flash array and turns the recognised patterns into single-cycle operation requests. Each write carries an address and a data word. Only the low sixteen address bits and the low data byte take part in the matching. Unlock handshakes of three and six writes select program, chip erase, sector erase, sector lockout and bypass entry. Single writes select erase suspend, erase resume and the short identification exit. A three-write handshake enters or leaves the identification mode.

When an operation is recognised, the block raises `cmd_valid` for one cycle and presents the operation code, the address and the data of the write that completed the sequence. The engine that carries out the operation sits downstream and is not part of this block. A sticky bypass mode makes every accepted write a program request. While the downstream engine reports that a program is running, all writes are dropped.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A synchronous active-high `rst` returns the sequencer to its idle state and clears `cmd_valid`, `cmd_addr`, `cmd_data`, `bypass_mode` and `id_mode` at the next rising edge. A sequence that was partly entered is abandoned.
- R2: The writes AA at 5555, 55 at 2AAA and A0 at 5555 arm a program. The fourth write then raises `cmd_valid` with op PROG, carrying that write's full address and data.
- R3: The prefix AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA is completed by a sixth write. 10 at 5555 gives CHIP_ERASE. 30 at any address gives SECT_ERASE. 40 at any address gives LOCK. The command carries the sixth write's address and data.
- R4: The same five-write prefix followed by A0 at 5555 sets `bypass_mode` and issues no command.
- R5: While `bypass_mode` is set, every accepted write issues PROG with its own address and data. This includes the codes B0, 30 and AA. Only `rst` clears the mode.
- R6: Outside a sequence, a single write of B0 at any address issues SUSPEND.
- R7: Outside a sequence, a single write of 30 issues RESUME. `cmd_addr` carries the full address, so bits 18 to 16 name the plane.
- R8: The writes AA@5555, 55@2AAA, 90@5555 set `id_mode`. The same prefix ending in F0@5555 clears it. So does a single F0 written at any address.
- R9: Address bits above 15 and data bits above 7 are not compared.
- R10: A write presented while `prog_busy` is high issues nothing, does not advance the sequence and leaves both mode flags unchanged.
- R11: A write that does not match the expected next step returns the sequencer to idle and issues no command.
- R12: `cmd_op` encodes NONE=0, PROG=1, CHIP_ERASE=2, SECT_ERASE=3, LOCK=4, SUSPEND=5, RESUME=6. `cmd_valid` and the mode flags change one cycle after the rising edge that samples the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| wr_en | input | 1 | Write strobe, one cycle per bus write |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| prog_busy | input | 1 | High while an embedded program runs |
| cmd_valid | output | 1 | One-cycle command pulse |
| cmd_op | output | 3 | Operation code (see R12) |
| cmd_addr | output | ADDR_W | Address of the completing write |
| cmd_data | output | DATA_W | Data of the completing write |
| bypass_mode | output | 1 | Single-write program mode is active |
| id_mode | output | 1 | Identification mode is active |

## Verification
Every result of this block appears in the cycle after the rising edge that samples the completing write. This holds for the command pulse with its operation code, address and data, and for the bypass and identification flags. The bench applies each write at a falling edge and holds it for exactly one rising edge. It samples the outputs 2 ns after that edge. This way each check observes the response to the write just applied, and the pulse is gone by the next check. For the cases where a write must be ignored or abandoned, the bench follows that write with a write that would otherwise complete a command, and confirms that no pulse appears.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [2:0] {
    OP_NONE       = 3'd0,
    OP_PROG       = 3'd1,
    OP_CHIP_ERASE = 3'd2,
    OP_SECT_ERASE = 3'd3,
    OP_LOCK       = 3'd4,
    OP_SUSPEND    = 3'd5,
    OP_RESUME     = 3'd6
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_KEY1, ST_KEY2, ST_PROG, ST_EXT1, ST_EXT2, ST_EXT3
  } st_e;

  localparam int CMP_AW = 16;
  localparam int CMP_DW = 8;
  localparam logic [CMP_AW-1:0] KEY_ADDR_A = 16'h5555;
  localparam logic [CMP_AW-1:0] KEY_ADDR_B = 16'h2AAA;

  // indices into the code-hit vector
  localparam int C_AA = 0;
  localparam int C_55 = 1;
  localparam int C_A0 = 2;
  localparam int C_80 = 3;
  localparam int C_90 = 4;
  localparam int C_F0 = 5;
  localparam int C_10 = 6;
  localparam int C_30 = 7;
  localparam int C_40 = 8;
  localparam int C_B0 = 9;
  localparam int NCODE = 10;

  function automatic logic [CMP_DW-1:0] code_val(input int idx);
    case (idx)
      C_AA:    return 8'hAA;
      C_55:    return 8'h55;
      C_A0:    return 8'hA0;
      C_80:    return 8'h80;
      C_90:    return 8'h90;
      C_F0:    return 8'hF0;
      C_10:    return 8'h10;
      C_30:    return 8'h30;
      C_40:    return 8'h40;
      default: return 8'hB0;
    endcase
  endfunction

endpackage

// File: rtl/fcd_match.sv
module fcd_match
  import fcd_pkg::*;
(
  input  logic [CMP_AW-1:0] cmp_addr,
  input  logic [CMP_DW-1:0] cmp_data,
  output logic              at_key_a,
  output logic              at_key_b,
  output logic [NCODE-1:0]  code_hit
);

  assign at_key_a = (cmp_addr == KEY_ADDR_A);
  assign at_key_b = (cmp_addr == KEY_ADDR_B);

  for (genvar i = 0; i < NCODE; i++) begin : g_code
    assign code_hit[i] = (cmp_data == code_val(i));
  end

endmodule

// File: rtl/fcd_seq.sv
module fcd_seq
  import fcd_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             prog_busy,
  input  logic             at_key_a,
  input  logic             at_key_b,
  input  logic [NCODE-1:0] code_hit,
  output logic             issue,
  output op_e              issue_op,
  output logic             bypass_q,
  output logic             id_q
);

  st_e  st_q, st_d;
  logic byp_d, id_d;
  logic take;

  assign take = wr_en && !prog_busy;

  always_comb begin
    st_d     = st_q;
    byp_d    = bypass_q;
    id_d     = id_q;
    issue    = 1'b0;
    issue_op = OP_NONE;
    if (take) begin
      if (bypass_q) begin
        issue    = 1'b1;
        issue_op = OP_PROG;
        st_d     = ST_IDLE;
      end else begin
        st_d = ST_IDLE;
        case (st_q)
          ST_IDLE: begin
            if (at_key_a && code_hit[C_AA]) st_d = ST_KEY1;
            else if (code_hit[C_B0]) begin
              issue = 1'b1; issue_op = OP_SUSPEND;
            end else if (code_hit[C_30]) begin
              issue = 1'b1; issue_op = OP_RESUME;
            end else if (code_hit[C_F0]) id_d = 1'b0;
          end
          ST_KEY1: if (at_key_b && code_hit[C_55]) st_d = ST_KEY2;
          ST_KEY2: if (at_key_a) begin
            if (code_hit[C_A0])      st_d = ST_PROG;
            else if (code_hit[C_80]) st_d = ST_EXT1;
            else if (code_hit[C_90]) id_d = 1'b1;
            else if (code_hit[C_F0]) id_d = 1'b0;
          end
          ST_PROG: begin
            issue = 1'b1; issue_op = OP_PROG;
          end
          ST_EXT1: if (at_key_a && code_hit[C_AA]) st_d = ST_EXT2;
          ST_EXT2: if (at_key_b && code_hit[C_55]) st_d = ST_EXT3;
          ST_EXT3: begin
            if (at_key_a && code_hit[C_10]) begin
              issue = 1'b1; issue_op = OP_CHIP_ERASE;
            end else if (code_hit[C_30]) begin
              issue = 1'b1; issue_op = OP_SECT_ERASE;
            end else if (code_hit[C_40]) begin
              issue = 1'b1; issue_op = OP_LOCK;
            end else if (at_key_a && code_hit[C_A0]) byp_d = 1'b1;
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      bypass_q <= 1'b0;
      id_q     <= 1'b0;
    end else begin
      st_q     <= st_d;
      bypass_q <= byp_d;
      id_q     <= id_d;
    end
  end

endmodule

// File: rtl/fcd_outreg.sv
module fcd_outreg
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  op_e               issue_op,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output op_e               out_op,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_op    <= OP_NONE;
      out_addr  <= '0;
      out_data  <= '0;
    end else begin
      out_valid <= issue;
      if (issue) begin
        out_op   <= issue_op;
        out_addr <= in_addr;
        out_data <= in_data;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_busy,
  output logic              cmd_valid,
  output logic [2:0]        cmd_op,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DATA_W-1:0] cmd_data,
  output logic              bypass_mode,
  output logic              id_mode
);

  logic             at_key_a, at_key_b;
  logic [NCODE-1:0] code_hit;
  logic             issue;
  op_e              issue_op;
  op_e              op_q;

  fcd_match u_match (
    .cmp_addr (wr_addr[CMP_AW-1:0]),
    .cmp_data (wr_data[CMP_DW-1:0]),
    .at_key_a (at_key_a),
    .at_key_b (at_key_b),
    .code_hit (code_hit)
  );

  fcd_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .prog_busy (prog_busy),
    .at_key_a  (at_key_a),
    .at_key_b  (at_key_b),
    .code_hit  (code_hit),
    .issue     (issue),
    .issue_op  (issue_op),
    .bypass_q  (bypass_mode),
    .id_q      (id_mode)
  );

  fcd_outreg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_out (
    .clk       (clk),
    .rst       (rst),
    .issue     (issue),
    .issue_op  (issue_op),
    .in_addr   (wr_addr),
    .in_data   (wr_data),
    .out_valid (cmd_valid),
    .out_op    (op_q),
    .out_addr  (cmd_addr),
    .out_data  (cmd_data)
  );

  assign cmd_op = op_q;

endmodule

// File: rtl/fcd_chk.sv
module fcd_chk
  import fcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              prog_busy,
  input logic              cmd_valid,
  input logic [2:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic [DATA_W-1:0] cmd_data,
  input logic              bypass_mode,
  input logic              id_mode
);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (!cmd_valid && !bypass_mode && !id_mode));

  assert_pulse_from_write_R10: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(wr_en && !prog_busy));

  assert_busy_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_en && prog_busy) |=> (!cmd_valid && $stable(bypass_mode) && $stable(id_mode)));

  assert_bypass_prog_R5: assert property (@(posedge clk) disable iff (rst)
    (bypass_mode && wr_en && !prog_busy) |=>
      (cmd_valid && cmd_op == OP_PROG &&
       cmd_addr == $past(wr_addr) && cmd_data == $past(wr_data)));

  assert_bypass_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    bypass_mode |=> bypass_mode);

  assert_op_coded_R12: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> (cmd_op != OP_NONE && cmd_op <= OP_RESUME));

endmodule

bind flash_cmd_decoder fcd_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/flash_cmd_decoder_test.sv
module flash_cmd_decoder_test;
  localparam int AW = 19;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          prog_busy = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          cmd_valid, bypass_mode, id_mode;
  logic [2:0]    cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;

  always #4 clk = ~clk;

  flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_busy(prog_busy), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .bypass_mode(bypass_mode),
    .id_mode(id_mode)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct packed {
    logic          r;
    logic          w;
    logic          b;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    logic          ev;
    logic [2:0]    eop;
    logic          eb;
    logic          eid;
    logic [3:0]    rq;
  } vec_t;

  function automatic vec_t v(input logic r, w, b, input logic [AW-1:0] a,
                             input logic [DW-1:0] d, input logic ev,
                             input logic [2:0] eop, input logic eb, eid,
                             input logic [3:0] rq);
    return '{r, w, b, a, d, ev, eop, eb, eid, rq};
  endfunction

  localparam int NV = 56;
  localparam vec_t VEC [NV] = '{
    v(1,0,0,19'h00000,16'h0000,0,0,0,0,1),   // R1 reset
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,2),   // R2 program
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,2),
    v(0,1,0,19'h05555,16'h00A0,0,0,0,0,2),
    v(0,1,0,19'h12345,16'hBEEF,1,1,0,0,2),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,3),   // R3 chip erase
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,3),
    v(0,1,0,19'h05555,16'h0080,0,0,0,0,3),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,3),
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,3),
    v(0,1,0,19'h05555,16'h0010,1,2,0,0,3),
    v(0,1,0,19'h35555,16'hFFAA,0,0,0,0,9),   // R9 upper bits ignored, R3 sector erase
    v(0,1,0,19'h42AAA,16'h1255,0,0,0,0,9),
    v(0,1,0,19'h05555,16'h7F80,0,0,0,0,9),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,3),
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,3),
    v(0,1,0,19'h48000,16'h0030,1,3,0,0,3),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,3),   // R3 lockout
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,3),
    v(0,1,0,19'h05555,16'h0080,0,0,0,0,3),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,3),
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,3),
    v(0,1,0,19'h01000,16'h0040,1,4,0,0,3),
    v(0,1,0,19'h1ABCD,16'h00B0,1,5,0,0,6),   // R6 suspend
    v(0,1,0,19'h50000,16'h0030,1,6,0,0,7),   // R7 resume plane 5
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,8),   // R8 id entry
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,8),
    v(0,1,0,19'h05555,16'h0090,0,0,0,1,8),
    v(0,1,0,19'h00777,16'h00F0,0,0,0,0,8),   // R8 single-write exit
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,8),
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,8),
    v(0,1,0,19'h05555,16'h0090,0,0,0,1,8),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,1,8),   // R8 three-write exit
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,1,8),
    v(0,1,0,19'h05555,16'h00F0,0,0,0,0,8),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,11),  // R11 wrong second address
    v(0,1,0,19'h01234,16'h0055,0,0,0,0,11),
    v(0,1,0,19'h05555,16'h00A0,0,0,0,0,11),
    v(0,1,0,19'h01111,16'h0022,0,0,0,0,11),
    v(0,1,1,19'h05555,16'h00AA,0,0,0,0,10),  // R10 busy write dropped
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,10),
    v(0,1,0,19'h05555,16'h00A0,0,0,0,0,10),
    v(0,1,0,19'h00333,16'h0044,0,0,0,0,10),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,4),   // R4 bypass entry
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,4),
    v(0,1,0,19'h05555,16'h0080,0,0,0,0,4),
    v(0,1,0,19'h05555,16'h00AA,0,0,0,0,4),
    v(0,1,0,19'h02AAA,16'h0055,0,0,0,0,4),
    v(0,1,0,19'h05555,16'h00A0,0,0,1,0,4),
    v(0,1,0,19'h00100,16'h1234,1,1,1,0,5),   // R5 bypass writes
    v(0,1,0,19'h00000,16'h00B0,1,1,1,0,5),
    v(0,1,0,19'h50000,16'h0030,1,1,1,0,5),
    v(0,1,0,19'h05555,16'h00AA,1,1,1,0,5),
    v(0,0,0,19'h00000,16'h0000,0,0,1,0,5),
    v(1,0,0,19'h00000,16'h0000,0,0,0,0,1),   // R1 reset leaves bypass
    v(0,1,0,19'h00200,16'h0030,1,6,0,0,7)    // R7 resume after reset
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic r, w, b, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    rst = r; wr_en = w; prog_busy = b; wr_addr = a; wr_data = d;
    @(posedge clk);
    #2;
  endtask

  task automatic prefix6();
    step(0,1,0,19'h05555,16'h00AA);
    step(0,1,0,19'h02AAA,16'h0055);
    step(0,1,0,19'h05555,16'h0080);
    step(0,1,0,19'h05555,16'h00AA);
    step(0,1,0,19'h02AAA,16'h0055);
  endtask

  initial begin
    repeat (3) step(1,0,0,'0,'0);
    chk("R1 reset valid", cmd_valid, 0);
    chk("R1 reset addr", cmd_addr, 0);
    chk("R1 reset data", cmd_data, 0);
    chk("R1 reset op", cmd_op, 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].r, VEC[i].w, VEC[i].b, VEC[i].a, VEC[i].d);
      chk($sformatf("R%0d valid v%0d", VEC[i].rq, i), cmd_valid, VEC[i].ev);
      chk($sformatf("R%0d bypass v%0d", VEC[i].rq, i), bypass_mode, VEC[i].eb);
      chk($sformatf("R%0d idmode v%0d", VEC[i].rq, i), id_mode, VEC[i].eid);
      if (VEC[i].ev) begin
        chk($sformatf("R12 op v%0d", i), cmd_op, VEC[i].eop);
        chk($sformatf("R%0d addr v%0d", VEC[i].rq, i), cmd_addr, VEC[i].a);
        chk($sformatf("R%0d data v%0d", VEC[i].rq, i), cmd_data, VEC[i].d);
      end
    end

    // R11: wrong sixth write abandons the erase, next write stays quiet
    prefix6();
    step(0,1,0,19'h05555,16'h0011);
    chk("R11 bad sixth write", cmd_valid, 0);
    step(0,1,0,19'h00400,16'h0040);
    chk("R11 idle after bad sixth", cmd_valid, 0);

    // R10: busy write while a program is armed, then real data
    step(0,1,0,19'h05555,16'h00AA);
    step(0,1,0,19'h02AAA,16'h0055);
    step(0,1,0,19'h05555,16'h00A0);
    step(0,1,1,19'h00ABC,16'h1111);
    chk("R10 busy during armed program", cmd_valid, 0);
    step(0,1,0,19'h00DEF,16'h2222);
    chk("R10 program after busy valid", cmd_valid, 1);
    chk("R10 program after busy addr", cmd_addr, 32'h00DEF);
    chk("R2 program after busy op", cmd_op, 1);

    // R1: reset in the middle of an armed program
    step(0,1,0,19'h05555,16'h00AA);
    step(0,1,0,19'h02AAA,16'h0055);
    step(0,1,0,19'h05555,16'h00A0);
    step(1,0,0,'0,'0);
    step(0,1,0,19'h01234,16'h0077);
    chk("R1 mid-sequence reset drops program", cmd_valid, 0);

    // R12: single-cycle pulse
    step(0,1,0,19'h00010,16'h00B0);
    chk("R6 suspend valid", cmd_valid, 1);
    step(0,0,0,'0,'0);
    chk("R12 pulse ends", cmd_valid, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule